// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This unit is the modem-handshake slice of one UART channel. Software writes an 8-bit control byte. The byte drives the active-low DTR and RTS output pins and gates the channel's interrupt line toward the system. Two of its bits together select the automatic flow-control mode that the transmitter and receiver apply. The unit also watches the four modem input pins: CTS, DSR, DCD and RI. It keeps a status byte of current levels and change flags. Any set change flag can raise a modem-status interrupt request.

A diagnostic loopback bit changes the routing in three ways:
- The serial input pin is dropped, and the transmit shift-register output is fed straight to the receive shift-register input.
- The serial output pin is parked at mark.
- The modem input pins are ignored. The status logic takes its inputs from the low four control bits instead, and the DTR and RTS pins are held inactive.

Software can therefore exercise the whole data path and the status and interrupt path without touching the line.

The shift registers, baud timing, FIFOs and interrupt prioritisation sit outside this unit. It connects to them through the serial hooks `tsr_out_i` and `rsr_in_o`, the flow-mode enables, `ms_irq_o` and `chan_irq_i`.

Top module: `mdm_ctrl_unit`

## Requirements
- R1: Outside loopback, `dtr_no` is the inverse of control bit 0 and `rts_no` is the inverse of control bit 1. Both follow a write from the clock edge that captures it.
- R2: Outside loopback, control bit 2 changes no output of the unit.
- R3: `irq_o` equals `chan_irq_i` while control bit 3 is set, and is 0 while control bit 3 is clear.
- R4: With loopback set (control bit 4):
  - `sout_o` is 1 and `rsr_in_o` equals `tsr_out_i`, and `sin_i` is ignored.
  - Outside loopback, `sout_o` equals `tsr_out_i` and `rsr_in_o` equals `sin_i`.
- R5: With loopback set, `dtr_no` and `rts_no` are 1 whatever control bits 0 and 1 hold.
- R6: With loopback set, the status inputs are taken from the control byte, one clock after the byte changes:
  - CTS from bit 1
  - DSR from bit 0
  - RI from bit 2
  - DCD from bit 3
- R7: With loopback set, changes on `cts_ni`, `dsr_ni`, `dcd_ni` and `ri_ni` alter neither the current-state bits nor the change flags.
- R8: Flow mode is decoded from control bit 5 and control bit 1:
  - Bit 5 set and bit 1 set give `auto_rts_en_o`=1 and `auto_cts_en_o`=1.
  - Bit 5 set and bit 1 clear give `auto_cts_en_o`=1 only.
  - Bit 5 clear gives both 0.
- R9: `msr_rdata_o` holds change flags in the low nibble and current states in the high nibble:
  - Bit 0 flags a CTS change, bit 1 a DSR change, bit 2 an RI trailing edge and bit 3 a DCD change.
  - Bits 4 to 7 hold the current CTS, DSR, RI and DCD states, each 1 when its pin is low.
  - A pin change shows in `msr_rdata_o` after the third rising clock edge.
  - The RI flag sets only when RI goes from active to inactive.
- R10: A cycle with `msr_rdata_o` read (`msr_re_i`=1) clears all four change flags at that clock edge. The current-state bits are not affected.
- R11: `ms_irq_o` is 1 exactly while `msi_en_i` is 1 and at least one change flag is set.
- R12: Reset has the following effect:
  - It clears the control byte and the status byte.
  - It leaves `dtr_no` and `rts_no` at 1 and both flow enables at 0.
  - `ctrl_rdata_o` returns the whole byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| ctrl_rdata_o | output | 8 | Control byte readback |
| msr_re_i | input | 1 | Status byte read strobe (clears change flags) |
| msr_rdata_o | output | 8 | Status byte: change flags [3:0], current states [7:4] |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| chan_irq_i | input | 1 | Channel interrupt from the priority logic |
| irq_o | output | 1 | Gated channel interrupt output |
| ms_irq_o | output | 1 | Modem-status interrupt request |
| dtr_no | output | 1 | DTR pin, active low |
| rts_no | output | 1 | RTS pin, active low |
| cts_ni | input | 1 | CTS pin, active low |
| dsr_ni | input | 1 | DSR pin, active low |
| dcd_ni | input | 1 | DCD pin, active low |
| ri_ni | input | 1 | RI pin, active low |
| sin_i | input | 1 | Serial input pin |
| sout_o | output | 1 | Serial output pin |
| tsr_out_i | input | 1 | Transmit shift-register output |
| rsr_in_o | output | 1 | Receive shift-register input |
| auto_rts_en_o | output | 1 | Automatic RTS flow control enable |
| auto_cts_en_o | output | 1 | Automatic CTS flow control enable |

## Verification
The assertions hold on every cycle for the following: the pin levels against the control byte, the loopback forcing of DTR, RTS and the serial pins, the interrupt gating, the flow-mode decode, and the mapping of control bits onto current-state bits in loopback. Only the bench scenarios can show the following:
- the three-edge latency of real pin changes
- the RI trailing-edge rule
- the clearing of flags on a status read
- the blindness of the status logic to pin activity while loopback is on
- the absence of any effect of bit 2 outside loopback

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned N_MDM    = 4;
  // control bit positions
  localparam int unsigned B_DTR    = 0;
  localparam int unsigned B_RTS    = 1;
  localparam int unsigned B_OUT1   = 2;
  localparam int unsigned B_OUT2   = 3;
  localparam int unsigned B_LOOP   = 4;
  localparam int unsigned B_AFE    = 5;
  // status vector positions
  localparam int unsigned S_CTS    = 0;
  localparam int unsigned S_DSR    = 1;
  localparam int unsigned S_RI     = 2;
  localparam int unsigned S_DCD    = 3;

  typedef enum logic [1:0] {
    FLOW_OFF  = 2'd0,
    FLOW_CTS  = 2'd1,
    FLOW_BOTH = 2'd2
  } flow_mode_e;
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
#(
  parameter int unsigned W = CTRL_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_o,
  output flow_mode_e   flow_o
);
  logic [W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i;
  end

  always_comb begin
    if (!ctrl_q[B_AFE])     flow_o = FLOW_OFF;
    else if (ctrl_q[B_RTS]) flow_o = FLOW_BOTH;
    else                    flow_o = FLOW_CTS;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
#(
  parameter int unsigned N    = N_MDM,
  parameter int unsigned RI_I = S_RI
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         rd_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] dlt_o
);
  logic [N-1:0] cur_q, dlt_q, chg;

  for (genvar i = 0; i < N; i++) begin : g_chg
    if (i == RI_I) begin : g_trail
      assign chg[i] = cur_q[i] & ~src_i[i];
    end else begin : g_any
      assign chg[i] = cur_q[i] ^ src_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      dlt_q <= '0;
    end else begin
      cur_q <= src_i;
      dlt_q <= (rd_i ? '0 : dlt_q) | chg;  // new change wins over clear
    end
  end

  assign cur_o = cur_q;
  assign dlt_o = dlt_q;
endmodule

// File: rtl/mdm_ctrl_unit.sv
module mdm_ctrl_unit
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              msr_re_i,
  output logic [7:0]        msr_rdata_o,
  input  logic              msi_en_i,
  input  logic              chan_irq_i,
  output logic              irq_o,
  output logic              ms_irq_o,
  output logic              dtr_no,
  output logic              rts_no,
  input  logic              cts_ni,
  input  logic              dsr_ni,
  input  logic              dcd_ni,
  input  logic              ri_ni,
  input  logic              sin_i,
  output logic              sout_o,
  input  logic              tsr_out_i,
  output logic              rsr_in_o,
  output logic              auto_rts_en_o,
  output logic              auto_cts_en_o
);
  logic [CTRL_W-1:0] ctrl;
  flow_mode_e        flow;
  logic [N_MDM-1:0]  pin_raw, pin_syn, loop_src, st_src, cur, dlt;
  logic              loop;

  mdm_ctrl_reg #(.W(CTRL_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl),
    .flow_o  (flow)
  );

  assign loop = ctrl[B_LOOP];

  // active-high internal view of the pins
  always_comb begin
    pin_raw        = '0;
    pin_raw[S_CTS] = ~cts_ni;
    pin_raw[S_DSR] = ~dsr_ni;
    pin_raw[S_RI]  = ~ri_ni;
    pin_raw[S_DCD] = ~dcd_ni;
  end

  mdm_sync #(.WIDTH(N_MDM), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_raw),
    .q_o    (pin_syn)
  );

  // loopback cross-wiring of outputs to status inputs
  always_comb begin
    loop_src        = '0;
    loop_src[S_CTS] = ctrl[B_RTS];
    loop_src[S_DSR] = ctrl[B_DTR];
    loop_src[S_RI]  = ctrl[B_OUT1];
    loop_src[S_DCD] = ctrl[B_OUT2];
  end

  assign st_src = loop ? loop_src : pin_syn;

  mdm_status #(.N(N_MDM), .RI_I(S_RI)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (st_src),
    .rd_i   (msr_re_i),
    .cur_o  (cur),
    .dlt_o  (dlt)
  );

  assign ctrl_rdata_o  = ctrl;
  assign msr_rdata_o   = {cur, dlt};
  assign ms_irq_o      = msi_en_i & (|dlt);
  assign irq_o         = ctrl[B_OUT2] & chan_irq_i;
  assign dtr_no        = loop | ~ctrl[B_DTR];
  assign rts_no        = loop | ~ctrl[B_RTS];
  assign sout_o        = loop | tsr_out_i;
  assign rsr_in_o      = loop ? tsr_out_i : sin_i;
  assign auto_cts_en_o = (flow != FLOW_OFF);
  assign auto_rts_en_o = (flow == FLOW_BOTH);
endmodule

// File: rtl/mdm_ctrl_chk.sv
module mdm_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ctrl_rdata_o,
  input logic [7:0] msr_rdata_o,
  input logic       msi_en_i,
  input logic       chan_irq_i,
  input logic       irq_o,
  input logic       ms_irq_o,
  input logic       dtr_no,
  input logic       rts_no,
  input logic       sout_o,
  input logic       tsr_out_i,
  input logic       rsr_in_o,
  input logic       auto_rts_en_o,
  input logic       auto_cts_en_o
);
  a_r1_pins_follow_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[4] |-> (dtr_no == !ctrl_rdata_o[0]) && (rts_no == !ctrl_rdata_o[1]));

  a_r3_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[3] |-> !irq_o);

  a_r3_irq_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[3] |-> (irq_o == chan_irq_i));

  a_r4_loop_serial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[4] |-> sout_o && (rsr_in_o == tsr_out_i));

  a_r5_loop_pins_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[4] |-> dtr_no && rts_no);

  a_r6_loop_status_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[4] && $past(ctrl_rdata_o[4]) |->
      msr_rdata_o[7:4] == {$past(ctrl_rdata_o[3]), $past(ctrl_rdata_o[2]),
                           $past(ctrl_rdata_o[0]), $past(ctrl_rdata_o[1])});

  a_r8_flow_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[5] |-> !auto_cts_en_o && !auto_rts_en_o);

  a_r8_flow_rts_needs_cts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_rts_en_o |-> auto_cts_en_o);

  a_r11_msi_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msi_en_i |-> !ms_irq_o);

  a_r11_no_flag_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rdata_o[3:0] == 4'h0) |-> !ms_irq_o);
endmodule

bind mdm_ctrl_unit mdm_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctrl_rdata_o  (ctrl_rdata_o),
  .msr_rdata_o   (msr_rdata_o),
  .msi_en_i      (msi_en_i),
  .chan_irq_i    (chan_irq_i),
  .irq_o         (irq_o),
  .ms_irq_o      (ms_irq_o),
  .dtr_no        (dtr_no),
  .rts_no        (rts_no),
  .sout_o        (sout_o),
  .tsr_out_i     (tsr_out_i),
  .rsr_in_o      (rsr_in_o),
  .auto_rts_en_o (auto_rts_en_o),
  .auto_cts_en_o (auto_cts_en_o)
);

// File: tb/sim_mdm_ctrl_unit.sv
`timescale 1ns/1ps
module sim_mdm_ctrl_unit;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       ctrl_we_i = 0, msr_re_i = 0, msi_en_i = 0, chan_irq_i = 0;
  logic [7:0] ctrl_wdata_i = 0, ctrl_rdata_o, msr_rdata_o;
  logic       irq_o, ms_irq_o, dtr_no, rts_no, sout_o, rsr_in_o;
  logic       cts_ni = 1, dsr_ni = 1, dcd_ni = 1, ri_ni = 1, sin_i = 1, tsr_out_i = 1;
  logic       auto_rts_en_o, auto_cts_en_o;
  int         n_chk = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  mdm_ctrl_unit u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; ctrl_we_i = 0; msr_re_i = 0; msi_en_i = 0; chan_irq_i = 0;
    cts_ni = 1; dsr_ni = 1; dcd_ni = 1; ri_ni = 1; sin_i = 1; tsr_out_i = 1;
    cyc(2);
    rst_ni = 1;
    cyc(1);
  endtask

  task automatic wr(input logic [7:0] d);
    ctrl_we_i = 1; ctrl_wdata_i = d;
    cyc(1);
    ctrl_we_i = 0;
  endtask

  task automatic rd_status();
    msr_re_i = 1;
    cyc(1);
    msr_re_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 ctrl", ctrl_rdata_o, 8'h00);
    chk("R12 status", msr_rdata_o, 8'h00);
    chk("R12 pins", {dtr_no, rts_no, auto_rts_en_o, auto_cts_en_o}, 8'b1100);
    wr(8'hC0);
    chk("R12 readback", ctrl_rdata_o, 8'hC0);
  endtask

  task automatic t_dtr_rts();
    do_reset();
    wr(8'h01); chk("R1 dtr", {dtr_no, rts_no}, 8'b01);
    wr(8'h02); chk("R1 rts", {dtr_no, rts_no}, 8'b10);
    wr(8'h03); chk("R1 both", {dtr_no, rts_no}, 8'b00);
  endtask

  task automatic t_bit2();
    do_reset();
    chan_irq_i = 1; msi_en_i = 1; tsr_out_i = 0; sin_i = 0;
    wr(8'h04); cyc(4);
    chk("R2 outs", {dtr_no, rts_no, irq_o, ms_irq_o, sout_o, rsr_in_o, auto_rts_en_o, auto_cts_en_o},
        8'b1100_0000);
    chk("R2 status", msr_rdata_o, 8'h00);
  endtask

  task automatic t_irq_gate();
    do_reset();
    chan_irq_i = 1; cyc(1);
    chk("R3 gated", {7'd0, irq_o}, 8'd0);
    wr(8'h08);
    chk("R3 pass", {7'd0, irq_o}, 8'd1);
    chan_irq_i = 0; cyc(1);
    chk("R3 follow", {7'd0, irq_o}, 8'd0);
  endtask

  task automatic t_flow();
    do_reset();
    wr(8'h22); chk("R8 both", {auto_rts_en_o, auto_cts_en_o}, 8'b11);
    wr(8'h20); chk("R8 cts", {auto_rts_en_o, auto_cts_en_o}, 8'b01);
    wr(8'h02); chk("R8 off", {auto_rts_en_o, auto_cts_en_o}, 8'b00);
  endtask

  task automatic t_serial();
    do_reset();
    tsr_out_i = 0; sin_i = 1; cyc(1);
    chk("R4 normal tx", {7'd0, sout_o}, 8'd0);
    chk("R4 normal rx", {7'd0, rsr_in_o}, 8'd1);
    wr(8'h13);
    chk("R4 loop tx mark", {7'd0, sout_o}, 8'd1);
    chk("R4 loop rx", {7'd0, rsr_in_o}, 8'd0);
    sin_i = 0; tsr_out_i = 1; cyc(1);
    chk("R4 sin ignored", {7'd0, rsr_in_o}, 8'd1);
    chk("R5 pins idle", {dtr_no, rts_no}, 8'b11);
  endtask

  task automatic t_ext_status();
    do_reset();
    msi_en_i = 1;
    cts_ni = 0; cyc(2);
    chk("R9 latency", msr_rdata_o, 8'h00);
    cyc(1);
    chk("R9 cts", msr_rdata_o, 8'h11);
    chk("R11 irq", {7'd0, ms_irq_o}, 8'd1);
    dsr_ni = 0; cyc(3);
    chk("R9 dsr", msr_rdata_o, 8'h33);
    rd_status();
    chk("R10 clear", msr_rdata_o, 8'h30);
    chk("R11 irq drop", {7'd0, ms_irq_o}, 8'd0);
    ri_ni = 0; cyc(3);
    chk("R9 ri lead no flag", msr_rdata_o, 8'h70);
    ri_ni = 1; cyc(3);
    chk("R9 ri trail", msr_rdata_o, 8'h34);
    msi_en_i = 0; cyc(1);
    chk("R11 disabled", {7'd0, ms_irq_o}, 8'd0);
    dcd_ni = 0; cyc(3);
    chk("R9 dcd", msr_rdata_o, 8'hBC);
  endtask

  task automatic t_loop_status();
    do_reset();
    wr(8'h10); cyc(2);
    chk("R6 enter", msr_rdata_o, 8'h00);
    wr(8'h1F); cyc(1);
    chk("R6 map up", msr_rdata_o, 8'hFB);
    rd_status();
    chk("R10 loop clear", msr_rdata_o, 8'hF0);
    wr(8'h18); cyc(1);
    chk("R6 map down", msr_rdata_o, 8'h87);
    cts_ni = 0; dsr_ni = 0; ri_ni = 0; dcd_ni = 0; cyc(4);
    chk("R7 pins ignored", msr_rdata_o, 8'h87);
    ri_ni = 1; dcd_ni = 1; rd_status(); cyc(4);
    chk("R7 no flags", msr_rdata_o, 8'h80);
  endtask

  initial begin
    t_reset();
    t_dtr_rts();
    t_bit2();
    t_irq_gate();
    t_flow();
    t_serial();
    t_ext_status();
    t_loop_status();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule